// File: doc/BRIEF.md
# Synchronous Serial Port Data Queue

This block sits between a simple register bus and the bit shifter of a synchronous serial port. It holds one queue for outgoing words and one for incoming words, and both are reached through a single 32-bit data word. A bus write places a word in the outgoing queue. A bus read takes the oldest word from the incoming queue.

Words change shape as they cross the block. A word that software writes right-aligned is masked to the programmed frame length. It is then moved up so that its top used bit sits at bit 31, which is where the shifter sends from first. A frame that arrives left-aligned from the shifter is moved down so that its lowest bit sits at bit 0.

The shifter side uses two valid/ready handshakes. Level flags against programmable thresholds let software or DMA logic pace its traffic. Clearing the port enable empties both queues at once.

Top module: `ssp_data_fifo`

## Requirements
- R1: A bus write with `wr_en` pushes one word into the transmit queue. A bus read with `rd_en` pops one word from the receive queue. `rd_data` always shows the oldest receive word.
- R2: The frame length is `data_size`+1 bits, and any `data_size` value below 3 is treated as 4 bits. Outside Microwire mode a transmit word is masked to that length and shifted left so that its top used bit lands at bit 31.
- R3: With `mw_mode`=1 the transmit length is 8 bits when `mw_cmd16`=0 and 16 bits when `mw_cmd16`=1, whatever `data_size` says. The upper bits of the written word are ignored.
- R4: A received frame arrives with its first bit at bit 31 of `rx_frame`. It is stored shifted right by 32 minus the `data_size` frame length, with its least significant bit at bit 0. This holds in Microwire mode too.
- R5: A write while the transmit queue holds 16 words is dropped, even if a pop happens in the same cycle. The queue contents and order stay unchanged.
- R6: A read while the receive queue is empty does not change its level, and `rd_data` reads zero whenever that queue is empty.
- R7: In the same cycle as each level change, `tx_full` is 1 at level 16 and `rx_empty` is 1 at level 0. `tx_low` is 1 when the transmit level is at or below `tx_thresh`. `rx_high` is 1 when the receive level is above `rx_thresh`.
- R8: While `port_en` is 0, both queues are held empty.
- R9: A received frame offered while the receive queue is full is dropped and sets the sticky `rx_overrun`. A one-cycle `ovr_clr` pulse clears it.
- R10: `tx_valid` is 1 while the transmit queue is non-empty, and each `tx_valid`&&`tx_ready` cycle pops one word in write order.
- R11: A bus read and a shifter push in the same cycle, or a bus write and a shifter pop in the same cycle, both take effect and leave the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_en | input | 1 | Port enable; 0 empties both queues |
| data_size | input | 5 | Frame length minus one |
| mw_mode | input | 1 | Microwire transmit width mode |
| mw_cmd16 | input | 1 | Microwire command width: 0 = 8 bits, 1 = 16 bits |
| tx_thresh | input | 4 | Transmit low threshold |
| rx_thresh | input | 4 | Receive high threshold |
| wr_en | input | 1 | Bus write strobe for the data word |
| wr_data | input | 32 | Bus write data, right-aligned |
| rd_en | input | 1 | Bus read strobe for the data word |
| rd_data | output | 32 | Oldest receive word, or zero when empty |
| tx_valid | output | 1 | Transmit word available to the shifter |
| tx_ready | input | 1 | Shifter takes the transmit word |
| tx_word | output | 32 | Left-justified transmit word |
| rx_valid | input | 1 | Shifter offers a received frame |
| rx_ready | output | 1 | Receive side accepts frames |
| rx_frame | input | 32 | Received frame, first bit at bit 31 |
| ovr_clr | input | 1 | Write-one-to-clear pulse for the overrun flag |
| tx_full | output | 1 | Transmit queue full |
| rx_empty | output | 1 | Receive queue empty |
| tx_low | output | 1 | Transmit level at or below threshold |
| rx_high | output | 1 | Receive level above threshold |
| rx_overrun | output | 1 | Sticky receive overrun flag |

## Verification
The bus side and the shifter side work on the same queue in the same clock cycle. A bus read can meet a shifter push on the receive queue, and a bus write can meet a shifter pop on the transmit queue. The bench arranges both cases by raising both strobes for one cycle on a queue that already holds words. It then judges the result by draining the queue: every word must come out in arrival order, and the queue must report empty exactly after the expected count. The full-queue case with a pop in the same cycle is held apart and checked against the drop rule.

// File: rtl/ssp_fifo_pkg.sv
package ssp_fifo_pkg;
   localparam int WORD_W = 32;
   localparam int DS_W   = 5;
   localparam int LEN_W  = 6;

   // frame length in bits from the size field; small codes clamp to 4
   function automatic logic [LEN_W-1:0] frame_len(input logic [DS_W-1:0] ds);
      if (ds < DS_W'(3)) return LEN_W'(4);
      return LEN_W'(ds) + LEN_W'(1);
   endfunction
endpackage

// File: rtl/ssp_sync_fifo.sv
module ssp_sync_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [LW-1:0] level,
   output logic          full,
   output logic          empty
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("ssp_sync_fifo: DEPTH must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("ssp_sync_fifo: W must be positive");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr, wnext, rnext;
   logic [LW-1:0] cnt;
   logic          push_ok, pop_ok;

   assign full    = (cnt == LW'(DEPTH));
   assign empty   = (cnt == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign level   = cnt;
   assign dout    = empty ? '0 : mem[rptr];

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
      assign wnext = wptr + AW'(1);
      assign rnext = rptr + AW'(1);
   end else begin : g_wrap_cmp
      assign wnext = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      assign rnext = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else if (clr) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (push_ok) wptr <= wnext;
         if (pop_ok)  rptr <= rnext;
         cnt <= cnt + LW'(push_ok) - LW'(pop_ok);
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok && !clr) mem[wptr] <= din;
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LW'(DEPTH)); // R5
   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !clr) |=> $stable(cnt)); // R5
   AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push && !clr) |=> (cnt == '0)); // R6
   AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0)); // R8
   AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && !full && !empty && !clr) |=> $stable(cnt)); // R11
endmodule

// File: rtl/ssp_tx_align.sv
module ssp_tx_align
   import ssp_fifo_pkg::*;
(
   input  logic [WORD_W-1:0] din,
   input  logic [DS_W-1:0]   data_size,
   input  logic              mw_mode,
   input  logic              mw_cmd16,
   output logic [WORD_W-1:0] dout
);
   logic [LEN_W-1:0]  len, shamt;
   logic [WORD_W-1:0] mask;

   always_comb begin
      if (mw_mode) len = mw_cmd16 ? LEN_W'(16) : LEN_W'(8);
      else         len = frame_len(data_size);
      shamt = LEN_W'(WORD_W) - len;
      mask  = {WORD_W{1'b1}} >> shamt;
      dout  = (din & mask) << shamt;
   end
endmodule

// File: rtl/ssp_rx_align.sv
module ssp_rx_align
   import ssp_fifo_pkg::*;
(
   input  logic [WORD_W-1:0] din,
   input  logic [DS_W-1:0]   data_size,
   output logic [WORD_W-1:0] dout
);
   logic [LEN_W-1:0] shamt;

   always_comb begin
      shamt = LEN_W'(WORD_W) - frame_len(data_size);
      dout  = din >> shamt;
   end
endmodule

// File: rtl/ssp_data_fifo.sv
module ssp_data_fifo
   import ssp_fifo_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   localparam int TH_W      = $clog2(FIFO_DEPTH),
   localparam int LV_W      = TH_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_en,
   input  logic [DS_W-1:0]   data_size,
   input  logic              mw_mode,
   input  logic              mw_cmd16,
   input  logic [TH_W-1:0]   tx_thresh,
   input  logic [TH_W-1:0]   rx_thresh,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [WORD_W-1:0] rd_data,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [WORD_W-1:0] tx_word,
   input  logic              rx_valid,
   output logic              rx_ready,
   input  logic [WORD_W-1:0] rx_frame,
   input  logic              ovr_clr,
   output logic              tx_full,
   output logic              rx_empty,
   output logic              tx_low,
   output logic              rx_high,
   output logic              rx_overrun
);
   logic [WORD_W-1:0] tx_just, rx_just;
   logic [LV_W-1:0]   tx_level, rx_level;
   logic              tx_empty, rx_full, clr, rx_take;

   assign clr      = !port_en;
   assign rx_ready = port_en;
   assign rx_take  = rx_valid && rx_ready;
   assign tx_valid = !tx_empty;

   ssp_tx_align u_txa (.din(wr_data), .data_size(data_size), .mw_mode(mw_mode),
                       .mw_cmd16(mw_cmd16), .dout(tx_just));
   ssp_rx_align u_rxa (.din(rx_frame), .data_size(data_size), .dout(rx_just));

   ssp_sync_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .clr(clr), .push(wr_en), .din(tx_just),
      .pop(tx_ready), .dout(tx_word), .level(tx_level), .full(tx_full), .empty(tx_empty));

   ssp_sync_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .clr(clr), .push(rx_take), .din(rx_just),
      .pop(rd_en), .dout(rd_data), .level(rx_level), .full(rx_full), .empty(rx_empty));

   assign tx_low  = (tx_level <= {1'b0, tx_thresh});
   assign rx_high = (rx_level >  {1'b0, rx_thresh});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 rx_overrun <= 1'b0;
      else if (rx_take && rx_full) rx_overrun <= 1'b1;
      else if (ovr_clr)            rx_overrun <= 1'b0;
   end

   AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_take && rx_full) |=> rx_overrun); // R9
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_overrun && !ovr_clr) |=> rx_overrun); // R9
   AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_full && tx_valid == 1'b0)); // R7
   AST_DISABLED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |=> (!tx_valid && rx_empty)); // R8
   AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rx_empty |-> (rd_data == '0)); // R6
endmodule

// File: tb/sim_ssp_data_fifo.sv
module sim_ssp_data_fifo;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        port_en = 1'b0;
   logic [4:0]  data_size = 5'd31;
   logic        mw_mode = 1'b0, mw_cmd16 = 1'b0;
   logic [3:0]  tx_thresh = 4'd3, rx_thresh = 4'd5;
   logic        wr_en = 1'b0, rd_en = 1'b0, tx_ready = 1'b0, rx_valid = 1'b0, ovr_clr = 1'b0;
   logic [31:0] wr_data = '0, rx_frame = '0;
   logic [31:0] rd_data, tx_word;
   logic        tx_valid, rx_ready, tx_full, rx_empty, tx_low, rx_high, rx_overrun;
   int          n_cmp = 0, n_bad = 0;

   always #2 clk = ~clk;

   ssp_data_fifo u0 (.*);

   task automatic tick(); @(negedge clk); endtask

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(logic [31:0] d);
      wr_en = 1'b1; wr_data = d; tick(); wr_en = 1'b0;
   endtask
   task automatic bus_rd(string tag, logic [31:0] exp);
      chk(tag, rd_data, exp); rd_en = 1'b1; tick(); rd_en = 1'b0;
   endtask
   task automatic sh_pop(string tag, logic [31:0] exp);
      chk({tag, " valid"}, 32'(tx_valid), 32'd1);
      chk(tag, tx_word, exp); tx_ready = 1'b1; tick(); tx_ready = 1'b0;
   endtask
   task automatic sh_push(logic [31:0] f);
      rx_valid = 1'b1; rx_frame = f; tick(); rx_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk("R7 reset tx_full", 32'(tx_full), 0);
      chk("R7 reset rx_empty", 32'(rx_empty), 1);
      chk("R10 reset tx_valid", 32'(tx_valid), 0);
      chk("R7 reset tx_low", 32'(tx_low), 1);
      chk("R7 reset rx_high", 32'(rx_high), 0);
      chk("R6 reset rd_data", rd_data, 0);
      chk("R9 reset overrun", 32'(rx_overrun), 0);
   endtask

   task automatic t_tx_justify();
      mw_mode = 1'b0;
      data_size = 5'd7;  bus_wr(32'hABCD_1234); sh_pop("R2 len8",  32'h3400_0000);
      data_size = 5'd15; bus_wr(32'hABCD_1234); sh_pop("R2 len16", 32'h1234_0000);
      data_size = 5'd31; bus_wr(32'hABCD_1234); sh_pop("R2 len32", 32'hABCD_1234);
      data_size = 5'd1;  bus_wr(32'hFFFF_FFF4); sh_pop("R2 clamp4", 32'h4000_0000);
      data_size = 5'd11; bus_wr(32'hABCD_1234); sh_pop("R2 len12", 32'h2340_0000);
   endtask

   task automatic t_microwire();
      mw_mode = 1'b1; data_size = 5'd31;
      mw_cmd16 = 1'b0; bus_wr(32'hDEAD_BEEF); sh_pop("R3 cmd8",  32'hEF00_0000);
      mw_cmd16 = 1'b1; bus_wr(32'hDEAD_BEEF); sh_pop("R3 cmd16", 32'hBEEF_0000);
      mw_mode = 1'b0; mw_cmd16 = 1'b0;
   endtask

   task automatic t_rx_justify();
      data_size = 5'd7;  sh_push(32'hA512_3456); bus_rd("R4 len8",  32'h0000_00A5);
      data_size = 5'd31; sh_push(32'h1357_9BDF); bus_rd("R4 len32", 32'h1357_9BDF);
      mw_mode = 1'b1; mw_cmd16 = 1'b0;
      data_size = 5'd11; sh_push(32'hABCF_FFFF); bus_rd("R4 mw len12", 32'h0000_0ABC);
      mw_mode = 1'b0;
   endtask

   task automatic t_tx_full();
      data_size = 5'd31; tx_thresh = 4'd3;
      for (int i = 0; i < 16; i++) begin
         bus_wr(32'(i + 1));
         if (i == 2) chk("R7 tx_low at 3", 32'(tx_low), 1);
         if (i == 3) chk("R7 tx_low at 4", 32'(tx_low), 0);
         if (i == 14) chk("R7 tx_full at 15", 32'(tx_full), 0);
      end
      chk("R7 tx_full at 16", 32'(tx_full), 1);
      bus_wr(32'h99);
      chk("R5 still full", 32'(tx_full), 1);
      // write while full with a pop in the same cycle is still dropped
      chk("R10 head", tx_word, 32'd1);
      wr_en = 1'b1; wr_data = 32'h77; tx_ready = 1'b1; tick(); wr_en = 1'b0; tx_ready = 1'b0;
      for (int i = 1; i < 16; i++) sh_pop("R5 order", 32'(i + 1));
      chk("R5 dropped word absent", 32'(tx_valid), 0);
   endtask

   task automatic t_rx_overrun();
      data_size = 5'd31; rx_thresh = 4'd5;
      for (int i = 0; i < 16; i++) begin
         sh_push(32'h100 + 32'(i));
         if (i == 4) chk("R7 rx_high at 5", 32'(rx_high), 0);
         if (i == 5) chk("R7 rx_high at 6", 32'(rx_high), 1);
      end
      chk("R9 no overrun yet", 32'(rx_overrun), 0);
      sh_push(32'hDEAD);
      chk("R9 overrun set", 32'(rx_overrun), 1);
      for (int i = 0; i < 16; i++) bus_rd("R1 rx order", 32'h100 + 32'(i));
      chk("R9 frame dropped", 32'(rx_empty), 1);
      bus_rd("R6 empty read", 32'h0);
      chk("R6 level unchanged", 32'(rx_empty), 1);
      chk("R9 sticky", 32'(rx_overrun), 1);
      ovr_clr = 1'b1; tick(); ovr_clr = 1'b0;
      chk("R9 cleared", 32'(rx_overrun), 0);
   endtask

   task automatic t_disable();
      bus_wr(32'h5); sh_push(32'h6);
      port_en = 1'b0; tick();
      chk("R8 tx emptied", 32'(tx_valid), 0);
      chk("R8 rx emptied", 32'(rx_empty), 1);
      bus_wr(32'h7);
      chk("R8 write held off", 32'(tx_valid), 0);
      port_en = 1'b1; tick();
      chk("R8 rd_data zero", rd_data, 0);
   endtask

   task automatic t_same_cycle();
      data_size = 5'd31;
      sh_push(32'hA); sh_push(32'hB);
      chk("R11 rx head", rd_data, 32'hA);
      rd_en = 1'b1; rx_valid = 1'b1; rx_frame = 32'hC; tick(); rd_en = 1'b0; rx_valid = 1'b0;
      bus_rd("R11 rx second", 32'hB);
      bus_rd("R11 rx third", 32'hC);
      chk("R11 rx drained", 32'(rx_empty), 1);
      bus_wr(32'hE);
      chk("R11 tx head", tx_word, 32'hE);
      wr_en = 1'b1; wr_data = 32'hF; tx_ready = 1'b1; tick(); wr_en = 1'b0; tx_ready = 1'b0;
      sh_pop("R11 tx second", 32'hF);
      chk("R11 tx drained", 32'(tx_valid), 0);
   endtask

   initial begin
      repeat (3) tick();
      t_reset();
      rst_n = 1'b1; tick();
      port_en = 1'b1; tick();
      t_tx_justify();
      t_microwire();
      t_rx_justify();
      t_tx_full();
      t_rx_overrun();
      t_disable();
      t_same_cycle();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule